// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmit/Receive Channel

This block moves one data word at a time over a clocked serial link, in both directions at once, through a single shift register. Software configures the channel through a control register and a rate register. A write to the data register then starts a transfer. The bits written leave on the serial output while the bits arriving on the serial input take their place. When the word is complete, the same register holds the received data.

The transfer clock comes from one of two places. In internal mode it is generated here, from a free-running prescaler followed by a programmable divider, and is driven out on the clock pin. In external mode it is taken from the clock input pin through a synchronizer. At the end of every word the block pulses an interrupt request.

In internal mode the serial output keeps the last bit for half a clock period after the final edge, then releases to high impedance. In external mode the output drives a programmed idle level between transfers.

Top module: `sync_serial_ch`

## Requirements
- R1: Register addresses are 0 = data, 1 = control, 2 = rate, 3 = status (bit 0 = busy). Control bit 6 selects internal (1) or external (0) clock. When control bit 3 is 1, a data write loads the shift register and starts an 8-bit transfer. Busy reads 1 from that write until the 8th rising transfer-clock edge.
- R2: In internal mode the transfer clock half-period is (n+1) source periods, where n is the rate register value. Control bits 1:0 pick the source: 00 = system clock, 01 = system clock / 8, 10 or 11 = system clock / 32.
- R3: When control bit 5 is 0, transmit and receive run LSB first. When it is 1, they run MSB first.
- R4: `irq_o` is high for exactly one cycle, in the cycle after the 8th rising transfer-clock edge of a transfer.
- R5: In internal mode `sclk_o` rests high and `sclk_oe` is 1. Output data changes on falling edges and input data is sampled on rising edges. After 8 edges the data register holds the received byte.
- R6: In internal mode `sdat_oe` stays 1 for one half-period after the last rising edge, then drops to 0.
- R7: In internal mode a data write while busy is ignored: neither the bits sent nor the bits received change.
- R8: In internal mode a data write during the half-period hold drops `sdat_oe` in the next cycle.
- R9: In external mode with port enabled, `sdat_oe` is 1. When not busy, `sdat_o` equals control bit 7; during a transfer it carries the first data bit from the write onward. `sclk_i` passes a two-flop synchronizer.
- R10: In external mode the register keeps shifting on `sclk_i` edges after the 8th bit, with busy low and no further interrupt.
- R11: When control bit 3 is 0, `sdat_oe` and `sclk_oe` are 0 and a data write leaves busy at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for writes and reads |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| sclk_i | input | 1 | External transfer clock |
| sclk_o | output | 1 | Generated transfer clock |
| sclk_oe | output | 1 | Drive enable for `sclk_o` |
| sdat_i | input | 1 | Serial data in |
| sdat_o | output | 1 | Serial data out |
| sdat_oe | output | 1 | Drive enable for `sdat_o` |
| busy_o | output | 1 | Transfer in progress |
| irq_o | output | 1 | End-of-word interrupt pulse |

## Verification
The hardest state to reach from the ports is the short window in internal mode after the last rising edge. In that window busy has already fallen but the output is still being driven. A data write must land inside it to show that the hold is cut short.

The stimulus runs with a divider value of 3, which makes the window four cycles long. The bench follows `sclk_o` cycle by cycle and issues the write in the same cycle in which it first sees busy low. A second hard case is a write that arrives mid-word. The bench injects it after sampling the fourth falling edge, then checks that the bits sent and the byte received both match the first word.

// File: rtl/sio_pkg.sv
package sio_pkg;
   localparam logic [1:0] ADDR_DATA = 2'd0;
   localparam logic [1:0] ADDR_CTRL = 2'd1;
   localparam logic [1:0] ADDR_RATE = 2'd2;
   localparam logic [1:0] ADDR_STAT = 2'd3;

   typedef struct packed {
      logic       idle_lvl;
      logic       int_clk;
      logic       msb_first;
      logic       spare4;
      logic       port_en;
      logic       spare2;
      logic [1:0] pre_sel;
   } sio_ctrl_t;
endpackage

// File: rtl/sio_rate_gen.sv
module sio_rate_gen #(
   parameter int RATE_W   = 8,
   parameter int MID_DIV  = 8,
   parameter int SLOW_DIV = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic [1:0]        pre_sel_i,
   input  logic [RATE_W-1:0] rate_i,
   output logic              half_tick_o
);
   localparam int MID_W  = $clog2(MID_DIV);
   localparam int SLOW_W = $clog2(SLOW_DIV);

   if ((1 << MID_W) != MID_DIV || (1 << SLOW_W) != SLOW_DIV || MID_W >= SLOW_W || MID_W < 1) begin : g_bad_div
      $error("sio_rate_gen: dividers must be powers of two with MID_DIV < SLOW_DIV");
   end

   logic [SLOW_W-1:0] pre_q;
   logic [RATE_W-1:0] cnt_q;
   logic              src_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + 1'b1;
   end

   always_comb begin
      unique case (pre_sel_i)
         2'b00:   src_tick = 1'b1;
         2'b01:   src_tick = &pre_q[MID_W-1:0];
         default: src_tick = &pre_q;
      endcase
   end

   assign half_tick_o = run_i && src_tick && (cnt_q >= rate_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!run_i)        cnt_q <= '0;
      else if (half_tick_o)   cnt_q <= '0;
      else if (src_tick)      cnt_q <= cnt_q + 1'b1;
   end

   // R2: every run window begins with a cleared divider
   assert_div_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_i) |-> (cnt_q == '0));
endmodule

// File: rtl/sio_edge_sync.sv
module sio_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sio_edge_sync: at least two stages required");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign rise_o = chain_q[STAGES-1] && !prev_q;
   assign fall_o = !chain_q[STAGES-1] && prev_q;

   // R9: a rise is never followed straight away by another rise
   assert_edge_alternate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] load_data_i,
   input  logic              msb_first_i,
   input  logic              sample_i,
   input  logic              drive_i,
   input  logic              sdi_i,
   output logic [DATA_W-1:0] sr_o,
   output logic              dout_o
);
   logic [DATA_W-1:0] sr_q;
   logic              out_bit;

   assign out_bit = msb_first_i ? sr_q[DATA_W-1] : sr_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sr_q <= '0;
      else if (load_i)   sr_q <= load_data_i;
      else if (sample_i) sr_q <= msb_first_i ? {sr_q[DATA_W-2:0], sdi_i}
                                             : {sdi_i, sr_q[DATA_W-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dout_o <= 1'b0;
      else if (load_i)  dout_o <= msb_first_i ? load_data_i[DATA_W-1] : load_data_i[0];
      else if (drive_i) dout_o <= out_bit;
   end

   assign sr_o = sr_q;

   // R3: in MSB-first order the sampled bit enters at the low end
   assert_msb_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_i && !load_i && msb_first_i) |=> (sr_q[0] == $past(sdi_i)));
endmodule

// File: rtl/sync_serial_ch.sv
module sync_serial_ch #(
   parameter int DATA_W      = 8,
   parameter int RATE_W      = 8,
   parameter int MID_DIV     = 8,
   parameter int SLOW_DIV    = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [1:0]        addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic              sclk_i,
   output logic              sclk_o,
   output logic              sclk_oe,
   input  logic              sdat_i,
   output logic              sdat_o,
   output logic              sdat_oe,
   output logic              busy_o,
   output logic              irq_o
);
   import sio_pkg::*;

   localparam int CNT_W = $clog2(DATA_W + 1);

   if (DATA_W < 8 || RATE_W > DATA_W || RATE_W < 1) begin : g_bad_width
      $error("sync_serial_ch: need DATA_W >= 8 and 1 <= RATE_W <= DATA_W");
   end

   sio_ctrl_t         ctrl_q;
   logic [RATE_W-1:0] rate_q;
   logic              busy_q, hold_q, drive_q, sclk_q, irq_q;
   logic [CNT_W-1:0]  bit_q;

   logic int_mode, data_wr, load, start, run, half_tick;
   logic ext_rise, ext_fall, int_rise, int_fall, sample, drive, last;
   logic [DATA_W-1:0] sr;
   logic              dout;

   assign int_mode = ctrl_q.int_clk;
   assign data_wr  = wr_en_i && (addr_i == ADDR_DATA);
   assign load     = data_wr && !(int_mode && busy_q);
   assign start    = load && ctrl_q.port_en;
   assign run      = int_mode && (busy_q || hold_q) && !start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         rate_q <= '0;
      end else if (wr_en_i) begin
         if (addr_i == ADDR_CTRL) ctrl_q <= sio_ctrl_t'(wdata_i[7:0]);
         if (addr_i == ADDR_RATE) rate_q <= wdata_i[RATE_W-1:0];
      end
   end

   sio_rate_gen #(.RATE_W(RATE_W), .MID_DIV(MID_DIV), .SLOW_DIV(SLOW_DIV)) i_rate (
      .clk(clk), .rst_n(rst_n), .run_i(run), .pre_sel_i(ctrl_q.pre_sel),
      .rate_i(rate_q), .half_tick_o(half_tick));

   sio_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .async_i(sclk_i), .rise_o(ext_rise), .fall_o(ext_fall));

   assign int_fall = int_mode && busy_q && half_tick && sclk_q;
   assign int_rise = int_mode && busy_q && half_tick && !sclk_q;
   assign sample   = int_rise || (!int_mode && ext_rise);
   assign drive    = int_fall || (!int_mode && ext_fall);
   assign last     = sample && busy_q && (bit_q == CNT_W'(DATA_W - 1));

   sio_shifter #(.DATA_W(DATA_W)) i_shift (
      .clk(clk), .rst_n(rst_n), .load_i(load), .load_data_i(wdata_i),
      .msb_first_i(ctrl_q.msb_first), .sample_i(sample), .drive_i(drive),
      .sdi_i(sdat_i), .sr_o(sr), .dout_o(dout));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         hold_q  <= 1'b0;
         drive_q <= 1'b0;
         sclk_q  <= 1'b1;
         irq_q   <= 1'b0;
         bit_q   <= '0;
      end else begin
         irq_q <= last;
         if (start) begin
            busy_q  <= 1'b1;
            hold_q  <= 1'b0;
            drive_q <= 1'b0;
            sclk_q  <= 1'b1;
            bit_q   <= '0;
         end else begin
            if (last) busy_q <= 1'b0;
            if (sample && busy_q) bit_q <= bit_q + 1'b1;
            if (int_fall) begin
               sclk_q  <= 1'b0;
               drive_q <= 1'b1;
            end
            if (int_rise) sclk_q <= 1'b1;
            if (last && int_mode) hold_q <= 1'b1;
            else if (hold_q && half_tick) begin
               hold_q  <= 1'b0;
               drive_q <= 1'b0;
            end
         end
      end
   end

   assign sclk_o  = sclk_q;
   assign sclk_oe = int_mode && ctrl_q.port_en;
   assign sdat_oe = ctrl_q.port_en && (int_mode ? drive_q : 1'b1);
   assign sdat_o  = (int_mode || busy_q) ? dout : ctrl_q.idle_lvl;
   assign busy_o  = busy_q;
   assign irq_o   = irq_q;

   always_comb begin
      rdata_o = '0;
      unique case (addr_i)
         ADDR_DATA: rdata_o = sr;
         ADDR_CTRL: rdata_o[7:0] = ctrl_q;
         ADDR_RATE: rdata_o[RATE_W-1:0] = rate_q;
         default:   rdata_o[0] = busy_q;
      endcase
   end

   // R4: an interrupt pulse always closes a transfer that was running
   assert_irq_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(busy_q));
   // R5: the generated clock rests high outside a transfer
   assert_clk_park_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (int_mode && !busy_q) |-> sclk_o);
   // R6: the output is still driven as the transfer ends
   assert_hold_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_q) && int_mode && ctrl_q.port_en) |-> sdat_oe);
   // R7: a data write in internal mode while busy leaves the shift register alone
   assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && int_mode && busy_q && !sample) |=> $stable(sr));
endmodule

// File: tb/test_sync_serial_ch.sv
`timescale 1ns/1ps
module test_sync_serial_ch;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       ext_clk = 1'b0;
   logic       sclk_o, sclk_oe, sdi = 1'b0, sdat_o, sdat_oe, busy, irq;

   int  n_checks = 0;
   int  n_fail   = 0;
   int  irq_cnt  = 0;
   bit  done     = 1'b0;

   always #4 clk = ~clk;

   sync_serial_ch i_sync_serial_ch (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
      .rdata_o(rdata), .sclk_i(ext_clk), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
      .sdat_i(sdi), .sdat_o(sdat_o), .sdat_oe(sdat_oe), .busy_o(busy), .irq_o(irq));

   always @(posedge clk) if (rst_n && irq) irq_cnt <= irq_cnt + 1;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; addr = 2'd0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      addr = a; #1; d = rdata; addr = 2'd0;
   endtask

   task automatic int_xfer(input logic [7:0] tx, input logic [7:0] rx, input bit msb,
                           input bit inject, output logic [7:0] got);
      got = 8'h00;
      wr(2'd0, tx);
      for (int i = 0; i < 8; i++) begin
         while (sclk_o !== 1'b0) @(negedge clk);
         got[msb ? 7 - i : i] = sdat_o;
         sdi = rx[msb ? 7 - i : i];
         if (inject && i == 3) wr(2'd0, 8'hFF);
         while (sclk_o !== 1'b1) @(negedge clk);
      end
      while (busy) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(2'd1, v); chk("R1 ctrl reset", v, 8'h00);
      rd(2'd3, v); chk("R1 status reset", v, 8'h00);
      chk("R11 reset enables", {sclk_oe, sdat_oe, irq}, 3'b000);
      chk("R5 reset clock level", sclk_o, 1'b1);
   endtask

   task automatic t_int_order(input bit msb, input logic [7:0] tx, input logic [7:0] rx);
      logic [7:0] got, v;
      int base;
      wr(2'd2, 8'h00);
      wr(2'd1, msb ? 8'h68 : 8'h48);
      base = irq_cnt;
      int_xfer(tx, rx, msb, 1'b0, got);
      chk(msb ? "R3 msb bits sent" : "R3 lsb bits sent", got, tx);
      chk("R4 irq pulse high", irq, 1'b1);
      chk("R6 hold drive", sdat_oe, 1'b1);
      @(negedge clk);
      chk("R4 irq one cycle", irq, 1'b0);
      chk("R4 irq count", irq_cnt - base, 1);
      rd(2'd0, v);
      chk(msb ? "R5 msb received" : "R5 lsb received", v, rx);
      chk("R5 clock parked", {sclk_o, sclk_oe}, 2'b11);
   endtask

   task automatic measure(input logic [7:0] ctrl, input logic [7:0] rate, input int exp);
      int c;
      wr(2'd2, rate);
      wr(2'd1, ctrl);
      wr(2'd0, 8'h55);
      while (sclk_o !== 1'b0) @(negedge clk);
      c = 0;
      while (sclk_o === 1'b0) begin @(negedge clk); c++; end
      while (sclk_o === 1'b1) begin @(negedge clk); c++; end
      chk("R2 clock period", c, exp);
      while (busy) @(negedge clk);
   endtask

   task automatic t_hold();
      logic [7:0] got;
      wr(2'd2, 8'h03);
      wr(2'd1, 8'h48);
      int_xfer(8'hC6, 8'h11, 1'b0, 1'b0, got);
      chk("R6 drive at end", sdat_oe, 1'b1);
      repeat (2) @(negedge clk);
      chk("R6 still held", sdat_oe, 1'b1);
      repeat (3) @(negedge clk);
      chk("R6 released", sdat_oe, 1'b0);
   endtask

   task automatic t_hold_cut();
      logic [7:0] got;
      wr(2'd2, 8'h03);
      wr(2'd1, 8'h48);
      int_xfer(8'h39, 8'h00, 1'b0, 1'b0, got);
      chk("R8 drive before write", sdat_oe, 1'b1);
      wr(2'd0, 8'h39);
      chk("R8 released on write", sdat_oe, 1'b0);
      chk("R1 new transfer busy", busy, 1'b1);
      while (busy) @(negedge clk);
      repeat (8) @(negedge clk);
   endtask

   task automatic t_busy_ignore();
      logic [7:0] got, v;
      wr(2'd2, 8'h03);
      wr(2'd1, 8'h48);
      int_xfer(8'h5A, 8'hE1, 1'b0, 1'b1, got);
      chk("R7 sent unchanged", got, 8'h5A);
      rd(2'd0, v);
      chk("R7 received unchanged", v, 8'hE1);
      repeat (8) @(negedge clk);
   endtask

   task automatic ext_bits(input logic [7:0] rx, output logic [7:0] got);
      got = 8'h00;
      for (int i = 0; i < 8; i++) begin
         repeat (6) @(negedge clk);
         got[i] = sdat_o;
         sdi = rx[i];
         ext_clk = 1'b1;
         repeat (6) @(negedge clk);
         ext_clk = 1'b0;
      end
      repeat (6) @(negedge clk);
   endtask

   task automatic t_ext();
      logic [7:0] got, v;
      int base;
      wr(2'd1, 8'h88);
      repeat (4) @(negedge clk);
      chk("R9 idle level high", {sdat_oe, sdat_o, sclk_oe}, 3'b110);
      base = irq_cnt;
      wr(2'd0, 8'h6B);
      chk("R9 first bit on write", sdat_o, 1'b1);
      chk("R1 ext busy", busy, 1'b1);
      ext_bits(8'h2E, got);
      chk("R9 ext bits sent", got, 8'h6B);
      rd(2'd0, v);
      chk("R9 ext received", v, 8'h2E);
      chk("R4 ext irq count", irq_cnt - base, 1);
      chk("R1 ext busy clear", busy, 1'b0);
      chk("R9 idle after word", sdat_o, 1'b1);
      wr(2'd1, 8'h08);
      chk("R9 idle level low", {sdat_oe, sdat_o}, 2'b10);
      ext_bits(8'hC3, got);
      rd(2'd0, v);
      chk("R10 shifting continues", v, 8'hC3);
      chk("R10 no extra irq", irq_cnt - base, 1);
      chk("R10 busy stays low", busy, 1'b0);
   endtask

   task automatic t_disabled();
      logic [7:0] v;
      wr(2'd1, 8'h40);
      wr(2'd0, 8'hA7);
      repeat (3) @(negedge clk);
      rd(2'd3, v);
      chk("R11 no start", v, 8'h00);
      chk("R11 drivers off", {sdat_oe, sclk_oe}, 2'b00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_int_order(1'b0, 8'h3C, 8'h96);
      t_int_order(1'b1, 8'hB4, 8'h2D);
      measure(8'h48, 8'h02, 6);
      measure(8'h49, 8'h01, 32);
      measure(8'h4A, 8'h00, 64);
      t_hold();
      t_hold_cut();
      t_busy_ignore();
      t_ext();
      t_disabled();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule